// File: doc/BRIEF.md
# Block-Circulant Spectral Matrix-Vector Multiplier

This block computes y = W·x, where W is an m x n weight matrix made of f x g square circulant tiles of size b (m = f·b, n = g·b). Every tile is described by one length-b index vector, and the block never receives that vector. It receives the vector's discrete Fourier spectrum, which is computed offline and held in an external coefficient memory. The input vector arrives one element per accepted cycle. The block splits it into g sub-vectors and transforms each one with a radix-2 FFT. Then, one output tile row at a time, it multiplies the stored spectra bin by bin with the input spectra, sums over the tile columns, and runs the result through the same FFT datapath with conjugated twiddles. The last step is a right shift by log2(b).

The output for each tile row is the sum of b-point circular convolutions of the index vectors with the input sub-vectors. Results stream out in tile-row order, and a flag marks the final element of the output vector. The tile size, the tile counts and all widths are parameters. The default is b = 4, where every twiddle factor is ±1 or ±j and the integer results are exact.

Top module: `bcm_mv`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `in_ready` is 1, and `out_valid` and `out_last` are 0. A reset in the middle of a computation abandons that computation.
- R2: An element is taken when `in_valid` and `in_ready` are both 1. The first accepted element is x[0] and the last is x[n-1], with n = COLB·BLK. `in_ready` stays 1 until the n-th element is taken and then drops.
- R3: While `in_ready` is 0, `in_valid` and `in_data` have no effect on any result.
- R4: While `wt_en` is 1, exactly one spectrum coefficient is read per cycle. Its address is (i·COLB + j)·BLK + k for tile row i, tile column j and bin k, in that nesting order, so the address runs 0,1,2,... within each input vector. `wt_re`/`wt_im` are the signed real and imaginary parts of bin k of the DFT of index vector p_ij (X[k] = Σ p[t]·e^(-j2πtk/BLK)). They are sampled in the same cycle as the address.
- R5: Output element n of tile row i equals Σ_j Σ_t p_ij[t]·x_j[(n−t) mod BLK], as a signed value of OW bits. This holds for any signed 16-bit input, including −32768 and 32767.
- R6: Outputs appear in order, tile row 0 first and element 0 first within a row. Each tile row is a run of exactly BLK consecutive `out_valid` cycles. `in_ready` is 0 whenever `out_valid` is 1.
- R7: `out_last` is 1 only together with `out_valid`, and only on the final element of the final tile row.
- R8: In the cycle after `out_last`, `in_ready` is 1 and a new input vector can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input element present |
| in_data | input | DW | Signed input element |
| in_ready | output | 1 | Block is collecting an input vector |
| wt_en | output | 1 | Spectrum coefficient read this cycle |
| wt_addr | output | AW | Spectrum coefficient address |
| wt_re | input | WW | Real part of addressed coefficient |
| wt_im | input | WW | Imaginary part of addressed coefficient |
| out_valid | output | 1 | Output element present |
| out_data | output | OW | Signed output element |
| out_last | output | 1 | Final element of the output vector |

## Verification
The multiplier is driven with several input patterns, and each one exposes a different kind of fault. A unit impulse in the first and in a later sub-vector returns one column of the circulant tiles, which exposes a reversed convolution direction or swapped tile columns. A constant vector reduces each tile to its row sums. Alternating full-scale extremes expose faults in sign extension and intermediate width. A ramp mixes all bins with distinct weights. Junk presented while the block is busy must leave the results untouched. A reset in mid-computation must return the block to collection.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
    localparam int IW  = 48;
    localparam int TWF = 14;

    typedef struct packed {
        logic signed [IW-1:0] re;
        logic signed [IW-1:0] im;
    } cplx_t;

    typedef enum logic [2:0] {
        S_LOAD, S_XFFT, S_MAC, S_IFFT, S_OUT
    } state_t;

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // cosine of a*pi/4 in Q14
    function automatic int cos8(input int a);
        case (a % 8)
            0: return 16384;
            1: return 11585;
            2: return 0;
            3: return -11585;
            4: return -16384;
            5: return -11585;
            6: return 0;
            default: return 11585;
        endcase
    endfunction

    // e^(-j*2*pi*k/n), conjugated when inv is set; n in {2,4,8}
    function automatic cplx_t twiddle(input int k, input int n, input logic inv);
        cplx_t w;
        int a, s;
        a = ((k * 8) / n) % 8;
        s = cos8((a + 6) % 8);
        w.re = IW'(cos8(a));
        w.im = inv ? IW'(s) : IW'(-s);
        return w;
    endfunction

    function automatic cplx_t cmul_tw(input cplx_t v, input cplx_t w);
        cplx_t r;
        logic signed [63:0] pr, pi;
        pr = 64'(v.re) * 64'(w.re) - 64'(v.im) * 64'(w.im);
        pi = 64'(v.re) * 64'(w.im) + 64'(v.im) * 64'(w.re);
        r.re = IW'(pr >>> TWF);
        r.im = IW'(pi >>> TWF);
        return r;
    endfunction

    function automatic cplx_t cadd(input cplx_t a, input cplx_t b);
        cplx_t r;
        r.re = a.re + b.re;
        r.im = a.im + b.im;
        return r;
    endfunction

    function automatic cplx_t csub(input cplx_t a, input cplx_t b);
        cplx_t r;
        r.re = a.re - b.re;
        r.im = a.im - b.im;
        return r;
    endfunction
endpackage

// File: rtl/bcm_fft.sv
module bcm_fft
    import bcm_pkg::*;
#(
    parameter int N = 4
) (
    input  cplx_t din  [N],
    input  logic  inv,
    output cplx_t dout [N]
);
    localparam int LG = $clog2(N);

    function automatic int bitrev(input int v);
        int r;
        r = 0;
        for (int b = 0; b < LG; b++)
            if (((v >> b) & 1) == 1) r = r | (1 << (LG - 1 - b));
        return r;
    endfunction

    always_comb begin
        cplx_t a [N];
        cplx_t u, v;
        for (int i = 0; i < N; i++) a[bitrev(i)] = din[i];
        for (int len = 2; len <= N; len = len * 2)
            for (int s = 0; s < N; s = s + len)
                for (int t = 0; t < len / 2; t++) begin
                    u = a[s + t];
                    v = cmul_tw(a[s + t + len / 2], twiddle(t, len, inv));
                    a[s + t]           = cadd(u, v);
                    a[s + t + len / 2] = csub(u, v);
                end
        for (int i = 0; i < N; i++) dout[i] = a[i];
    end
endmodule

// File: rtl/bcm_cmac.sv
module bcm_cmac
    import bcm_pkg::*;
#(
    parameter int WW = 16
) (
    input  cplx_t                 acc_in,
    input  cplx_t                 xs,
    input  logic signed [WW-1:0]  w_re,
    input  logic signed [WW-1:0]  w_im,
    output cplx_t                 acc_out
);
    logic signed [IW-1:0] wr, wi;
    assign wr = IW'(w_re);
    assign wi = IW'(w_im);
    assign acc_out.re = acc_in.re + (xs.re * wr - xs.im * wi);
    assign acc_out.im = acc_in.im + (xs.re * wi + xs.im * wr);
endmodule

// File: rtl/bcm_mv.sv
module bcm_mv
    import bcm_pkg::*;
#(
    parameter int BLK  = 4,
    parameter int ROWB = 2,
    parameter int COLB = 2,
    parameter int DW   = 16,
    parameter int WW   = 16,
    parameter int OW   = 32,
    localparam int AW  = cw(ROWB * COLB * BLK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [DW-1:0]  in_data,
    output logic                  in_ready,
    output logic                  wt_en,
    output logic [AW-1:0]         wt_addr,
    input  logic signed [WW-1:0]  wt_re,
    input  logic signed [WW-1:0]  wt_im,
    output logic                  out_valid,
    output logic signed [OW-1:0]  out_data,
    output logic                  out_last
);
    localparam int NIN = COLB * BLK;
    localparam int LW  = cw(NIN);
    localparam int JW  = cw(COLB);
    localparam int KW  = cw(BLK);
    localparam int RW  = cw(ROWB);
    localparam int LGB = $clog2(BLK);
    localparam logic [LW-1:0] LLAST = LW'(NIN - 1);
    localparam logic [JW-1:0] JLAST = JW'(COLB - 1);
    localparam logic [KW-1:0] KLAST = KW'(BLK - 1);
    localparam logic [RW-1:0] RLAST = RW'(ROWB - 1);

    state_t               state;
    logic [LW-1:0]        lcnt;
    logic [JW-1:0]        jcnt;
    logic [KW-1:0]        kcnt, ocnt;
    logic [RW-1:0]        icnt;
    logic signed [DW-1:0] xbuf  [NIN];
    cplx_t                xspec [COLB][BLK];
    cplx_t                acc   [BLK];
    logic signed [OW-1:0] ybuf  [BLK];
    cplx_t                fin   [BLK];
    cplx_t                fout  [BLK];
    cplx_t                mac_q;

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            if (state == S_IFFT) begin
                fin[k] = acc[k];
            end else begin
                fin[k].re = IW'(xbuf[int'(jcnt) * BLK + k]);
                fin[k].im = '0;
            end
        end
    end

    bcm_fft #(.N(BLK)) u_fft (
        .din  (fin),
        .inv  (state == S_IFFT),
        .dout (fout)
    );

    bcm_cmac #(.WW(WW)) u_mac (
        .acc_in  (acc[kcnt]),
        .xs      (xspec[jcnt][kcnt]),
        .w_re    (wt_re),
        .w_im    (wt_im),
        .acc_out (mac_q)
    );

    assign in_ready  = (state == S_LOAD);
    assign wt_en     = (state == S_MAC);
    assign wt_addr   = AW'((int'(icnt) * COLB + int'(jcnt)) * BLK + int'(kcnt));
    assign out_valid = (state == S_OUT);
    assign out_data  = ybuf[ocnt];
    assign out_last  = (state == S_OUT) && (icnt == RLAST) && (ocnt == KLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_LOAD;
            lcnt  <= '0;
            jcnt  <= '0;
            kcnt  <= '0;
            ocnt  <= '0;
            icnt  <= '0;
        end else begin
            case (state)
                S_LOAD: if (in_valid) begin
                    xbuf[lcnt] <= in_data;
                    if (lcnt == LLAST) begin
                        lcnt  <= '0;
                        jcnt  <= '0;
                        state <= S_XFFT;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                S_XFFT: begin
                    xspec[jcnt] <= fout;
                    if (jcnt == JLAST) begin
                        jcnt <= '0;
                        kcnt <= '0;
                        for (int k = 0; k < BLK; k++) acc[k] <= '0;
                        state <= S_MAC;
                    end else begin
                        jcnt <= jcnt + 1'b1;
                    end
                end
                S_MAC: begin
                    acc[kcnt] <= mac_q;
                    if (kcnt == KLAST) begin
                        kcnt <= '0;
                        if (jcnt == JLAST) begin
                            jcnt  <= '0;
                            state <= S_IFFT;
                        end else begin
                            jcnt <= jcnt + 1'b1;
                        end
                    end else begin
                        kcnt <= kcnt + 1'b1;
                    end
                end
                S_IFFT: begin
                    for (int k = 0; k < BLK; k++) ybuf[k] <= OW'(fout[k].re >>> LGB);
                    ocnt  <= '0;
                    state <= S_OUT;
                end
                default: begin
                    if (ocnt == KLAST) begin
                        ocnt <= '0;
                        if (icnt == RLAST) begin
                            icnt  <= '0;
                            state <= S_LOAD;
                        end else begin
                            icnt <= icnt + 1'b1;
                            for (int k = 0; k < BLK; k++) acc[k] <= '0;
                            state <= S_MAC;
                        end
                    end else begin
                        ocnt <= ocnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bcm_mv_chk.sv
module bcm_mv_chk #(
    parameter int BLK = 4
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_last
);
    int rl;
    always_ff @(posedge clk) begin
        if (rst) rl <= 0;
        else     rl <= out_valid ? rl + 1 : 0;
    end

    AST_READY_AFTER_RESET: assert property (@(posedge clk) rst |=> (in_ready && !out_valid)); // R1
    AST_READY_DROP:  assert property (@(posedge clk) disable iff (rst) $fell(in_ready) |-> $past(in_valid)); // R2
    AST_OUT_EXCL:    assert property (@(posedge clk) disable iff (rst) out_valid |-> !in_ready); // R6
    AST_RUN_MAX:     assert property (@(posedge clk) disable iff (rst) out_valid |-> (rl < BLK)); // R6
    AST_RUN_LEN:     assert property (@(posedge clk) disable iff (rst) (!out_valid && rl != 0) |-> (rl == BLK)); // R6
    AST_LAST_VALID:  assert property (@(posedge clk) disable iff (rst) out_last |-> out_valid); // R7
    AST_RESTART:     assert property (@(posedge clk) disable iff (rst) out_last |=> in_ready); // R8
endmodule

bind bcm_mv bcm_mv_chk #(.BLK(BLK)) u_chk (.*);

// File: tb/sim_bcm_mv.sv
module sim_bcm_mv;
    localparam int BLK = 4, ROWB = 2, COLB = 2, NIN = COLB * BLK, NOUT = ROWB * BLK;
    localparam int NV = 5;
    localparam logic signed [15:0] VEC [NV][NIN] = '{
        '{16'sd1, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0},
        '{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd1, 16'sd0},
        '{16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd1},
        '{-16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767,
          16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768},
        '{16'sd3, -16'sd7, 16'sd11, 16'sd250, -16'sd1000, 16'sd42, 16'sd5, -16'sd9}
    };

    logic clk = 0, rst = 1, in_valid = 0;
    logic signed [15:0] in_data = '0;
    logic in_ready, wt_en, out_valid, out_last;
    logic [3:0] wt_addr;
    logic signed [15:0] wt_re, wt_im;
    logic signed [31:0] out_data;

    int checks = 0, fails = 0, rcnt = 0, macn = 0;
    int rx [NOUT];
    logic rl [NOUT];

    always #4 clk = ~clk;

    function automatic int pidx(input int i, input int j, input int t);
        return ((i * 5 + j * 3 + t * 7) % 9) - 4;
    endfunction

    function automatic int spec(input int a, input bit im);
        int i, j, k, s;
        i = a / (COLB * BLK); j = (a / BLK) % COLB; k = a % BLK; s = 0;
        for (int t = 0; t < BLK; t++)
            case ((t * k) % 4)
                0: s += im ? 0 : pidx(i, j, t);
                1: s += im ? -pidx(i, j, t) : 0;
                2: s += im ? 0 : -pidx(i, j, t);
                default: s += im ? pidx(i, j, t) : 0;
            endcase
        return s;
    endfunction

    assign wt_re = 16'(spec(int'(wt_addr), 1'b0));
    assign wt_im = 16'(spec(int'(wt_addr), 1'b1));

    function automatic int expy(input int v, input int o);
        int i, n, s;
        i = o / BLK; n = o % BLK; s = 0;
        for (int j = 0; j < COLB; j++)
            for (int t = 0; t < BLK; t++)
                s += pidx(i, j, t) * int'(VEC[v][j * BLK + (n - t + BLK) % BLK]);
        return s;
    endfunction

    bcm_mv u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (out_valid && rcnt < NOUT) begin
            rx[rcnt] = out_data;
            rl[rcnt] = out_last;
            rcnt++;
        end
        if (wt_en) begin
            chk(int'(wt_addr) == macn % (ROWB * COLB * BLK), "R4 coefficient address", int'(wt_addr), macn);
            macn++;
        end
    end

    task automatic run_vec(input int v, input bit junk);
        int bad;
        rcnt = 0; macn = 0;
        for (int e = 0; e < NIN; e++) begin
            @(negedge clk);
            if (e == 0) chk(in_ready == 1'b1, "R2 ready at start", int'(in_ready), 1);
            in_valid = 1; in_data = VEC[v][e];
        end
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready drops after n elements", int'(in_ready), 0);
        in_valid = junk; in_data = 16'sh7ABC;
        while (!out_last) @(negedge clk);
        in_valid = 0;
        #1;
        chk(rcnt == NOUT, "R6 output count", rcnt, NOUT);
        bad = 0;
        for (int o = 0; o < NOUT; o++) begin
            chk(rx[o] == expy(v, o), junk ? "R5 R3 result with junk offered" : "R5 result", rx[o], expy(v, o));
            if (rx[o] != expy(v, o)) bad++;
            chk(rl[o] == (o == NOUT - 1), "R7 last flag", int'(rl[o]), int'(o == NOUT - 1));
        end
        if (junk) chk(bad == 0, "R3 busy input ignored", bad, 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready after last", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1 reset last", int'(out_last), 0);
        rst = 0;
        for (int v = 0; v < NV; v++) run_vec(v, v[0]);
        // mid-computation reset
        for (int e = 0; e < NIN; e++) begin
            @(negedge clk); in_valid = 1; in_data = 16'sd99;
        end
        @(negedge clk); in_valid = 0;
        repeat (6) @(negedge clk);
        rst = 1;
        @(negedge clk); @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset mid-run ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset mid-run valid", int'(out_valid), 0);
        rst = 0;
        run_vec(4, 1'b0);
        run_vec(3, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule